// File: doc/BRIEF.md
# Receive-side PRBS lock and bit/error measurement

This block sits on the receive side of a bit-error-rate test path. It takes a serial stream, one bit per cycle on which the bit-enable strobe is high, optionally inverts it, and checks it against a locally regenerated pseudorandom sequence. Before it can check anything, it must lock. It fills its reference shift register with received bits, one bit for each stage of the selected polynomial. It then predicts each following bit and declares lock after a run of correct predictions.

While locked, the reference free-runs on its own predictions. Every enabled bit then counts as a received bit, and every wrong prediction also counts as an error. A dense burst of errors drops the lock, and acquisition then restarts by itself. A host starts a measurement period with a rising edge on the latch request. That edge copies both running counts into holding outputs and restarts both counts. A rising edge on the resync request throws away the lock and forces a new acquisition.

Top module: `bert_rx_sync_count`

## Requirements
- R1: After reset, `in_sync` is 0 and both `bit_hold` and `err_hold` are 0.
- R2: Patterns follow b[n] = b[n-L] ^ b[n-T], where b[n] is the n-th received bit, first bit first. The `pat_sel` codes are 000 (L=7, T=6), 001 (L=11, T=9), 010 (L=15, T=14) and 111 (L=9, T=5). On an error-free stream, `in_sync` stays 0 through the first L+31 enabled bits after acquisition starts, and it reads 1 once bit L+32 has been clocked.
- R3: Code 011 selects L=20, T=17. When the 14 most recent bits are all 0, the next bit is forced to 1 and the recurrence is not applied. The block locks on such a stream and counts no errors on it.
- R4: With `pat_sel` at 100, 101 or 110, `in_sync` stays 0 whatever the input.
- R5: Both running counts advance only on cycles where `bit_en` is high and `in_sync` was already 1. The bit count advances on each such bit. The error count advances when the received bit, after inversion, differs from the prediction.
- R6: While locked, if 6 or more errors fall within the most recent 64 locked bits, `in_sync` drops in the cycle after the bit that completes the count, and acquisition restarts without host action. Bits received while not locked are not counted.
- R7: A 0-to-1 change on `latch_req` copies both running counts to `bit_hold` and `err_hold` and clears them. Holding `latch_req` at 1 does not repeat the copy.
- R8: If a counted bit arrives in the same cycle as a latch edge, it is not in the copied values and becomes the first count of the new period.
- R9: Neither running count wraps. Each stops at all-ones (2^BIT_W-1 and 2^ERR_W-1).
- R10: A 0-to-1 change on `resync_req` clears `in_sync` in the next cycle and starts a fresh acquisition. Holding `resync_req` at 1 does not prevent the next lock or break it again.
- R11: With `rx_invert` at 1, each received bit is complemented before it is checked, so a complemented pattern stream locks and counts no errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries a received bit |
| rx_data | input | 1 | Received serial bit |
| rx_invert | input | 1 | Complement received bits before checking |
| pat_sel | input | 3 | Pattern code (see R2, R3, R4) |
| resync_req | input | 1 | Rising edge forces reacquisition |
| latch_req | input | 1 | Rising edge latches and clears the counts |
| in_sync | output | 1 | Pattern lock flag |
| bit_hold | output | BIT_W (32) | Latched received-bit count |
| err_hold | output | ERR_W (24) | Latched bit-error count |

## Verification
The bench builds the block with BIT_W=12 and ERR_W=6 and keeps the default lock run, window and loss threshold. With these widths, both counters reach their ceilings within a few thousand bits. A stream with one error every 16 bits can therefore drive the error count well past 63 without ever tripping the loss rule, which makes the saturation behaviour observable. The lock timing, the loss burst and the same-cycle latch case then run at the specified thresholds.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

   typedef enum logic [1:0] {
      ST_LOAD   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_LOCKED = 2'd2
   } sync_st_t;

   localparam int REF_W = 20;
   localparam int LEN_W = 5;

   typedef struct packed {
      logic             ok;
      logic             qrss;
      logic [LEN_W-1:0] len;
      logic [LEN_W-1:0] tap;
   } pat_cfg_t;

   function automatic pat_cfg_t decode_pat(input logic [2:0] code);
      pat_cfg_t r;
      r.ok   = 1'b1;
      r.qrss = 1'b0;
      r.len  = 5'd7;
      r.tap  = 5'd6;
      case (code)
         3'b000: begin r.len = 5'd7;  r.tap = 5'd6;  end
         3'b001: begin r.len = 5'd11; r.tap = 5'd9;  end
         3'b010: begin r.len = 5'd15; r.tap = 5'd14; end
         3'b011: begin r.len = 5'd20; r.tap = 5'd17; r.qrss = 1'b1; end
         3'b111: begin r.len = 5'd9;  r.tap = 5'd5;  end
         default: r.ok = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bert_rx_ref.sv
module bert_rx_ref #(
   parameter int REG_W = 20,
   parameter int ZRUN  = 14,
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             use_rx,
   input  logic             rx_bit,
   input  logic             qrss,
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] tap,
   output logic             pred
);

   generate
      if (ZRUN < 1 || ZRUN > REG_W) begin : g_bad_zrun
         $error("bert_rx_ref: ZRUN must lie in 1..REG_W");
      end
      if ((1 << LEN_W) <= REG_W) begin : g_bad_lenw
         $error("bert_rx_ref: LEN_W too narrow for REG_W");
      end
   endgenerate

   logic [REG_W-1:0] sr;
   logic             fb;

   always_comb begin
      fb   = sr[len - 1'b1] ^ sr[tap - 1'b1];
      pred = (qrss && (sr[ZRUN-1:0] == '0)) ? 1'b1 : fb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (adv)
         sr <= {sr[REG_W-2:0], (use_rx ? rx_bit : pred)};
   end

endmodule

// File: rtl/bert_rx_lock.sv
module bert_rx_lock
   import bert_rx_pkg::*;
#(
   parameter int SYNC_RUN  = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERRS = 6,
   parameter int LW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          mismatch,
   input  logic          force_acq,
   input  logic [LW-1:0] len,
   output logic          locked,
   output logic          use_rx
);

   localparam int CNT_W = ($clog2(SYNC_RUN) > LW) ? $clog2(SYNC_RUN) : LW;
   localparam int WC_W  = $clog2(WIN + 1);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(SYNC_RUN - 1);
   localparam logic [WC_W:0]    LOSS_LIM = (WC_W+1)'(LOSS_ERRS);

   generate
      if (SYNC_RUN < 1) begin : g_bad_run
         $error("bert_rx_lock: SYNC_RUN must be at least 1");
      end
      if (WIN < 2 || LOSS_ERRS < 1 || LOSS_ERRS > WIN) begin : g_bad_win
         $error("bert_rx_lock: need WIN >= 2 and 1 <= LOSS_ERRS <= WIN");
      end
   endgenerate

   sync_st_t         st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_last;
   logic [WIN-1:0]   hist;
   logic [WC_W-1:0]  wcnt;
   logic [WC_W:0]    wsum;
   logic             lose;

   assign load_last = CNT_W'(len) - 1'b1;

   // sliding window: add the newest error flag, drop the one leaving the window
   always_comb begin
      wsum = {1'b0, wcnt} + {{WC_W{1'b0}}, mismatch} - {{WC_W{1'b0}}, hist[WIN-1]};
      lose = (wsum >= LOSS_LIM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_LOAD;
         cnt  <= '0;
         hist <= '0;
         wcnt <= '0;
      end else if (force_acq) begin
         st   <= ST_LOAD;
         cnt  <= '0;
         hist <= '0;
         wcnt <= '0;
      end else if (en) begin
         case (st)
            ST_LOAD: begin
               if (cnt == load_last) begin
                  st  <= ST_VERIFY;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_VERIFY: begin
               if (mismatch) begin
                  st  <= ST_LOAD;
                  cnt <= '0;
               end else if (cnt == RUN_LAST) begin
                  st  <= ST_LOCKED;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_LOCKED: begin
               if (lose) begin
                  st   <= ST_LOAD;
                  hist <= '0;
                  wcnt <= '0;
               end else begin
                  hist <= {hist[WIN-2:0], mismatch};
                  wcnt <= wsum[WC_W-1:0];
               end
            end
            default: st <= ST_LOAD;
         endcase
      end
   end

   assign locked = (st == ST_LOCKED);
   assign use_rx = ~locked;

endmodule

// File: rtl/bert_rx_satcnt.sv
module bert_rx_satcnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         latch,
   output logic [W-1:0] run,
   output logic [W-1:0] hold
);

   generate
      if (W < 2) begin : g_bad_w
         $error("bert_rx_satcnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= '0;
         hold <= '0;
      end else if (latch) begin
         hold <= run;
         run  <= {{(W-1){1'b0}}, inc};
      end else if (inc && (run != '1)) begin
         run <= run + 1'b1;
      end
   end

endmodule

// File: rtl/bert_rx_sync_count.sv
module bert_rx_sync_count
   import bert_rx_pkg::*;
#(
   parameter int BIT_W     = 32,
   parameter int ERR_W     = 24,
   parameter int SYNC_RUN  = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERRS = 6,
   parameter int ZRUN      = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             rx_data,
   input  logic             rx_invert,
   input  logic [2:0]       pat_sel,
   input  logic             resync_req,
   input  logic             latch_req,
   output logic             in_sync,
   output logic [BIT_W-1:0] bit_hold,
   output logic [ERR_W-1:0] err_hold
);

   pat_cfg_t         cfg;
   logic             lat_q, rs_q;
   logic             lat_rise, rs_rise;
   logic             d_in, pred, mismatch, use_rx, force_acq, cnt_inc;
   logic [BIT_W-1:0] bit_run;
   logic [ERR_W-1:0] err_run;

   assign cfg = decode_pat(pat_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 1'b0;
         rs_q  <= 1'b0;
      end else begin
         lat_q <= latch_req;
         rs_q  <= resync_req;
      end
   end

   assign lat_rise  = latch_req & ~lat_q;
   assign rs_rise   = resync_req & ~rs_q;
   assign d_in      = rx_data ^ rx_invert;
   assign mismatch  = d_in ^ pred;
   assign force_acq = rs_rise | ~cfg.ok;
   assign cnt_inc   = bit_en & in_sync;

   bert_rx_ref #(.REG_W(REF_W), .ZRUN(ZRUN), .LEN_W(LEN_W)) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (bit_en),
      .use_rx (use_rx),
      .rx_bit (d_in),
      .qrss   (cfg.qrss),
      .len    (cfg.len),
      .tap    (cfg.tap),
      .pred   (pred)
   );

   bert_rx_lock #(.SYNC_RUN(SYNC_RUN), .WIN(WIN), .LOSS_ERRS(LOSS_ERRS), .LW(LEN_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (bit_en),
      .mismatch  (mismatch),
      .force_acq (force_acq),
      .len       (cfg.len),
      .locked    (in_sync),
      .use_rx    (use_rx)
   );

   bert_rx_satcnt #(.W(BIT_W)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .latch (lat_rise),
      .run   (bit_run),
      .hold  (bit_hold)
   );

   bert_rx_satcnt #(.W(ERR_W)) u_errs (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc & mismatch),
      .latch (lat_rise),
      .run   (err_run),
      .hold  (err_hold)
   );

endmodule

// File: rtl/bert_rx_sync_count_sva.sv
module bert_rx_sync_count_sva #(
   parameter int BIT_W = 32,
   parameter int ERR_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             in_sync,
   input logic             lat_rise,
   input logic             rs_rise,
   input logic             pat_ok,
   input logic [BIT_W-1:0] bit_run,
   input logic [ERR_W-1:0] err_run,
   input logic [BIT_W-1:0] bit_hold,
   input logic [ERR_W-1:0] err_hold
);

   a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rise |=> (bit_hold == $past(bit_run)) && (err_hold == $past(err_run)));

   a_r8_fresh_period: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_rise && !(bit_en && in_sync)) |=> (bit_run == '0) && (err_run == '0));

   a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_rise && !(bit_en && in_sync)) |=> $stable(bit_run) && $stable(err_run));

   a_r9_bits_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_rise && (bit_run == '1)) |=> (bit_run == '1));

   a_r9_errs_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_rise && (err_run == '1)) |=> (err_run == '1));

   a_r10_resync_drops: assert property (@(posedge clk) disable iff (!rst_n)
      rs_rise |=> !in_sync);

   a_r4_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_ok |=> !in_sync);

   a_r2_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(bit_en));

endmodule

bind bert_rx_sync_count bert_rx_sync_count_sva #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .in_sync  (in_sync),
   .lat_rise (lat_rise),
   .rs_rise  (rs_rise),
   .pat_ok   (cfg.ok),
   .bit_run  (bit_run),
   .err_run  (err_run),
   .bit_hold (bit_hold),
   .err_hold (err_hold)
);

// File: tb/bert_rx_sync_count_test.sv
module bert_rx_sync_count_test;

   localparam int CLK_P = 10;
   localparam int BIT_W = 12;
   localparam int ERR_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_en = 1'b0;
   logic             rx_data = 1'b0;
   logic             rx_invert = 1'b0;
   logic [2:0]       pat_sel = 3'b000;
   logic             resync_req = 1'b0;
   logic             latch_req = 1'b0;
   logic             in_sync;
   logic [BIT_W-1:0] bit_hold;
   logic [ERR_W-1:0] err_hold;

   bert_rx_sync_count #(.BIT_W(BIT_W), .ERR_W(ERR_W)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .rx_data    (rx_data),
      .rx_invert  (rx_invert),
      .pat_sel    (pat_sel),
      .resync_req (resync_req),
      .latch_req  (latch_req),
      .in_sync    (in_sync),
      .bit_hold   (bit_hold),
      .err_hold   (err_hold)
   );

   always #(CLK_P/2) clk = ~clk;

   // scoreboard items: kind 0 = in_sync, 1 = bit_hold, 2 = err_hold
   typedef struct {
      string  tag;
      int     kind;
      longint exp;
   } item_t;

   item_t  sb_q[$];
   item_t  cur;
   longint got;
   int     n_cmp = 0;
   int     n_bad = 0;
   bit     done = 1'b0;

   // generator model
   logic [19:0] gsr = 20'h1;
   logic [2:0]  gcode = 3'b000;
   logic        tx_inv = 1'b0;

   function automatic logic gen_peek();
      case (gcode)
         3'b001:  return gsr[10] ^ gsr[8];
         3'b010:  return gsr[14] ^ gsr[13];
         3'b011:  return (gsr[13:0] == 14'd0) ? 1'b1 : (gsr[19] ^ gsr[16]);
         3'b111:  return gsr[8] ^ gsr[4];
         default: return gsr[6] ^ gsr[5];
      endcase
   endfunction

   task automatic push(input string tag, input int kind, input longint exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic settle();
      @(posedge clk); #1;
      bit_en = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(posedge clk); #1;
      rx_data = b;
      bit_en  = 1'b1;
   endtask

   // n pattern bits; every err_every-th bit is complemented (0 = none)
   task automatic send_pat(input int n, input int err_every);
      for (int i = 0; i < n; i++) begin
         logic g;
         logic bad;
         g   = gen_peek();
         gsr = {gsr[18:0], g};
         bad = (err_every > 0) && ((i % err_every) == (err_every - 1));
         send_bit(g ^ tx_inv ^ bad);
      end
   endtask

   task automatic latch_pulse();
      @(posedge clk); #1;
      bit_en = 1'b0;
      latch_req = 1'b1;
      @(posedge clk); #1;
      latch_req = 1'b0;
   endtask

   task automatic resync_pulse();
      @(posedge clk); #1;
      bit_en = 1'b0;
      resync_req = 1'b1;
      @(posedge clk); #1;
      resync_req = 1'b0;
   endtask

   task automatic lock_check(input int len, input string tag);
      send_pat(len + 31, 0);
      settle();
      push(tag, 0, 0);
      send_pat(1, 0);
      settle();
      push(tag, 0, 1);
   endtask

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         case (cur.kind)
            0:       got = longint'(in_sync);
            1:       got = longint'(bit_hold);
            default: got = longint'(err_hold);
         endcase
         n_cmp++;
         if (got != cur.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d got %0d expected %0d", cur.tag, cur.kind, got, cur.exp);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      push("R1", 0, 0);
      push("R1", 1, 0);
      push("R1", 2, 0);

      // R2: 2^7-1 lock timing
      gcode = 3'b000; gsr = 20'h1;
      lock_check(7, "R2");

      // R5: counting with three spaced errors
      latch_pulse();
      send_pat(100, 33);
      latch_pulse();
      push("R5", 1, 100);
      push("R5", 2, 3);
      latch_pulse();
      push("R7", 1, 0);
      push("R7", 2, 0);

      // R7: level held high does not re-latch
      @(posedge clk); #1 latch_req = 1'b1;
      send_pat(10, 0);
      settle();
      push("R7", 1, 0);
      @(posedge clk); #1 latch_req = 1'b0;
      latch_pulse();
      push("R7", 1, 10);

      // R8: counted error bit on the latch edge
      begin
         logic g;
         g = gen_peek();
         gsr = {gsr[18:0], g};
         @(posedge clk); #1;
         rx_data = ~g; bit_en = 1'b1; latch_req = 1'b1;
         @(posedge clk); #1;
         bit_en = 1'b0; latch_req = 1'b0;
      end
      latch_pulse();
      push("R8", 1, 1);
      push("R8", 2, 1);

      // R6: loss on the sixth error in the window, then automatic relock
      send_pat(70, 0);
      latch_pulse();
      push("R5", 1, 70);
      push("R5", 2, 0);
      send_pat(5, 1);
      settle();
      push("R6", 0, 1);
      send_pat(1, 1);
      settle();
      push("R6", 0, 0);
      lock_check(7, "R6");
      latch_pulse();
      push("R6", 1, 6);
      push("R6", 2, 6);

      // R10: resync edge, level kept high
      @(posedge clk); #1 resync_req = 1'b1;
      settle();
      push("R10", 0, 0);
      lock_check(7, "R10");
      send_pat(20, 0);
      settle();
      push("R10", 0, 1);
      @(posedge clk); #1 resync_req = 1'b0;

      // R11: inverted 2^11-1 stream
      pat_sel = 3'b001; gcode = 3'b001; gsr = 20'h5A5;
      rx_invert = 1'b1; tx_inv = 1'b1;
      resync_pulse();
      lock_check(11, "R11");
      latch_pulse();
      send_pat(50, 0);
      latch_pulse();
      push("R11", 1, 50);
      push("R11", 2, 0);
      rx_invert = 1'b0; tx_inv = 1'b0;

      // R2: 2^15-1 and 2^9-1
      pat_sel = 3'b010; gcode = 3'b010; gsr = 20'h1234;
      resync_pulse();
      lock_check(15, "R2");
      pat_sel = 3'b111; gcode = 3'b111; gsr = 20'h0FF;
      resync_pulse();
      lock_check(9, "R2");

      // R3: QRSS from an all-zero seed (forced ones appear at once)
      pat_sel = 3'b011; gcode = 3'b011; gsr = 20'h0;
      resync_pulse();
      lock_check(20, "R3");
      latch_pulse();
      send_pat(400, 0);
      latch_pulse();
      push("R3", 1, 400);
      push("R3", 2, 0);

      // R4: unsupported code never locks
      pat_sel = 3'b100; gcode = 3'b000; gsr = 20'h1;
      resync_pulse();
      send_pat(200, 0);
      settle();
      push("R4", 0, 0);

      // R9: saturation of both counters
      pat_sel = 3'b000; gcode = 3'b000; gsr = 20'h3;
      resync_pulse();
      lock_check(7, "R9");
      latch_pulse();
      send_pat(4200, 16);
      settle();
      push("R9", 0, 1);
      latch_pulse();
      push("R9", 1, (1 << BIT_W) - 1);
      push("R9", 2, (1 << ERR_W) - 1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule